// File: doc/BRIEF.md
# Timer Channel Start Trigger Logic

This block holds the start-trigger registers of a four-channel timer array. Software starts a channel by writing 1 to its bit in the lower trigger register. Channels that can be split into two 8-bit halves have a second register that starts only their upper halves. Each accepted trigger gives a one-clock start pulse, so the counter reloads its initial value, and sets a per-channel enable level that the counter uses to run. Trigger bits clear themselves one clock after they are written, and both registers always read as zero.

Stop requests from a separate write-1 stop register come in as per-channel inputs and clear the enable levels. A start for the same bit in the same cycle takes priority over the stop. The block also tracks a settling window per channel after that channel changes to a function that uses its external input pin. A start that falls inside the window is flagged. The start still takes effect.

Top module: `tsc_top`

## Requirements
- R1: A write of 1 to lower trigger bit n (bits 0 to 3 = channels 0 to 3) makes `start_lo_o[n]` high in the cycle after the write edge, and `en_lo_o[n]` is 1 from the next cycle on. A write of 0 changes nothing.
- R2: A trigger bit clears itself. The start pulse lasts exactly one clock unless the bit is written again.
- R3: `rd_data_o` is always 0x00, whatever has been written.
- R4: After reset, all enable levels, start pulses and early flags are 0.
- R5: Lower-register bits 4 to 7 and upper-register bits 0, 2 and 4 to 7 are ignored on write.
- R6: Upper-register bits 1 and 3 pulse `start_hi_o` and set `en_hi_o` only for channels 1 and 3. They leave the lower-half outputs unchanged.
- R7: With `mode8_i[n]`=1 for channel 1 or 3, a lower trigger starts only the lower half. With `mode8_i[n]`=0, a lower trigger also pulses `start_hi_o[n]` and sets `en_hi_o[n]`.
- R8: After a `pin_chg_i[n]` pulse at edge m, a lower start of channel n written at an edge earlier than m+4 (when `nf_en_i[n]`=1) or m+2 (when `nf_en_i[n]`=0) raises `early_o[n]` together with its start pulse. A start written at or after that edge does not.
- R9: A trigger to a channel that is already enabled still produces the start pulse.
- R10: `stop_lo_i[n]`/`stop_hi_i[n]` held over an edge clear the matching enable bit. In 16-bit mode a lower stop of channel 1 or 3 also clears its upper enable. A start pending in the same cycle wins.
- R11: In single-bit mode (`wr_bit_i`=1), a write affects only the bit at `wr_idx_i`, with value `wr_val_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = lower trigger register, 1 = upper |
| wr_bit_i | input | 1 | 1 = single-bit write |
| wr_idx_i | input | 3 | Bit index for single-bit write |
| wr_val_i | input | 1 | Bit value for single-bit write |
| wr_data_i | input | 8 | Byte for full write |
| rd_data_o | output | 8 | Trigger register read data (always zero) |
| mode8_i | input | 4 | Per-channel 8-bit split mode |
| stop_lo_i | input | 4 | Per-channel lower stop request |
| stop_hi_i | input | 4 | Per-channel upper stop request |
| pin_chg_i | input | 4 | Pulse: channel switched to a pin-input function |
| nf_en_i | input | 4 | Per-channel input noise filter enabled |
| start_lo_o | output | 4 | Lower/whole counter start pulse |
| start_hi_o | output | 4 | Upper-half start pulse |
| en_lo_o | output | 4 | Lower/whole enable level |
| en_hi_o | output | 4 | Upper-half enable level |
| early_o | output | 4 | Start arrived inside the settling window |

## Verification
On every cycle, the assertions check that each start pulse is followed by the matching enable level, and that an enable level never rises without a start in the cycle before. They also check that a stop with no competing start always drops the enable, and that an early flag only ever comes with a start pulse. The bench scenarios are needed for the rest. These are: masking of the reserved bits, the reads that always return zero, the effect of 8-bit versus 16-bit mode on the upper half, single-bit writes, retriggers, start winning over stop, and the exact cycle boundary of the two settling windows.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int REG_W = 8;
  typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} trig_sel_e;
endpackage

// File: rtl/tsc_wr_decode.sv
module tsc_wr_decode import tsc_pkg::*; #(
  parameter int NCH = 4,
  parameter logic [NCH-1:0] HI_MASK = 4'b1010
) (
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic             wr_bit_i,
  input  logic [2:0]       wr_idx_i,
  input  logic             wr_val_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [NCH-1:0]   set_lo_o,
  output logic [NCH-1:0]   set_hi_o
);
  logic [REG_W-1:0] wbyte;

  always_comb begin
    if (wr_bit_i) wbyte = REG_W'(wr_val_i) << wr_idx_i;
    else          wbyte = wr_data_i;
  end

  // Reserved bits dropped here; zero bits carry no action.
  always_comb begin
    set_lo_o = '0;
    set_hi_o = '0;
    if (wr_en_i) begin
      if (trig_sel_e'(wr_sel_i) == SEL_LO) set_lo_o = wbyte[NCH-1:0];
      else                                  set_hi_o = wbyte[NCH-1:0] & HI_MASK;
    end
  end
endmodule

// File: rtl/tsc_settle.sv
module tsc_settle #(
  parameter int NCH      = 4,
  parameter int WAIT_NF  = 4,
  parameter int WAIT_RAW = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] pin_chg_i,
  input  logic [NCH-1:0] nf_en_i,
  output logic [NCH-1:0] busy_o
);
  localparam int WMAX = (WAIT_NF > WAIT_RAW) ? WAIT_NF : WAIT_RAW;
  localparam int CW   = $clog2(WMAX + 1);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           cnt_q <= '0;
      else if (pin_chg_i[n]) cnt_q <= nf_en_i[n] ? CW'(WAIT_NF) : CW'(WAIT_RAW);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o[n] = (cnt_q != '0);
  end
endmodule

// File: rtl/tsc_en_bank.sv
module tsc_en_bank #(
  parameter int NCH = 4,
  parameter logic [NCH-1:0] MASK = '1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] en_o
);
  logic [NCH-1:0] en_q;

  // set after clear: start beats stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= ((en_q & ~clr_i) | set_i) & MASK;
  end
  assign en_o = en_q;

  assert_set_enables_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((en_o & $past(set_i)) == $past(set_i)));

  assert_stop_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((en_o & $past(clr_i & ~set_i)) == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_rise_needs_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_q[n]) |-> $past(set_i[n]));
  end
endmodule

// File: rtl/tsc_top.sv
module tsc_top import tsc_pkg::*; #(
  parameter int NCH      = 4,
  parameter logic [NCH-1:0] SPLIT_MASK = 4'b1010,
  parameter int WAIT_NF  = 4,
  parameter int WAIT_RAW = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic             wr_bit_i,
  input  logic [2:0]       wr_idx_i,
  input  logic             wr_val_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [NCH-1:0]   mode8_i,
  input  logic [NCH-1:0]   stop_lo_i,
  input  logic [NCH-1:0]   stop_hi_i,
  input  logic [NCH-1:0]   pin_chg_i,
  input  logic [NCH-1:0]   nf_en_i,
  output logic [NCH-1:0]   start_lo_o,
  output logic [NCH-1:0]   start_hi_o,
  output logic [NCH-1:0]   en_lo_o,
  output logic [NCH-1:0]   en_hi_o,
  output logic [NCH-1:0]   early_o
);
  logic [NCH-1:0] set_lo, set_hi;
  logic [NCH-1:0] trig_lo_q, trig_hi_q;
  logic [NCH-1:0] whole16, clr_hi, busy;

  tsc_wr_decode #(.NCH(NCH), .HI_MASK(SPLIT_MASK)) u_dec (
    .wr_en_i, .wr_sel_i, .wr_bit_i, .wr_idx_i, .wr_val_i, .wr_data_i,
    .set_lo_o(set_lo), .set_hi_o(set_hi)
  );

  // Trigger bits live one cycle: cleared as the enable takes them.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_lo_q <= '0;
      trig_hi_q <= '0;
    end else begin
      trig_lo_q <= set_lo;
      trig_hi_q <= set_hi;
    end
  end

  assign rd_data_o = '0;  // trigger registers read back as zero

  assign whole16    = SPLIT_MASK & ~mode8_i;
  assign start_lo_o = trig_lo_q;
  assign start_hi_o = trig_hi_q | (trig_lo_q & whole16);
  assign clr_hi     = stop_hi_i | (stop_lo_i & whole16);

  tsc_en_bank #(.NCH(NCH), .MASK('1)) u_en_lo (
    .clk_i, .rst_ni, .set_i(start_lo_o), .clr_i(stop_lo_i), .en_o(en_lo_o)
  );

  tsc_en_bank #(.NCH(NCH), .MASK(SPLIT_MASK)) u_en_hi (
    .clk_i, .rst_ni, .set_i(start_hi_o), .clr_i(clr_hi), .en_o(en_hi_o)
  );

  tsc_settle #(.NCH(NCH), .WAIT_NF(WAIT_NF), .WAIT_RAW(WAIT_RAW)) u_settle (
    .clk_i, .rst_ni, .pin_chg_i, .nf_en_i, .busy_o(busy)
  );

  assign early_o = trig_lo_q & busy;

  assert_early_with_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_o & ~start_lo_o) == '0);

  assert_hi_start_split_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_hi_o) |=> ((en_hi_o & $past(start_hi_o)) == $past(start_hi_o)));
endmodule

// File: tb/sim_tsc_top.sv
module sim_tsc_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, wr_bit = 1'b0, wr_val = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [3:0] mode8 = '0, stop_lo = '0, stop_hi = '0, pin_chg = '0, nf_en = '0;
  logic [3:0] start_lo, start_hi, en_lo, en_hi, early;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_bit_i(wr_bit),
    .wr_idx_i(wr_idx), .wr_val_i(wr_val), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .mode8_i(mode8), .stop_lo_i(stop_lo), .stop_hi_i(stop_hi), .pin_chg_i(pin_chg),
    .nf_en_i(nf_en), .start_lo_o(start_lo), .start_hi_o(start_hi), .en_lo_o(en_lo),
    .en_hi_o(en_hi), .early_o(early)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Returns at the negedge of the cycle after the capturing edge.
  task automatic wr_byte(logic sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_bit = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr_one(logic sel, logic [2:0] idx, logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_bit = 1'b1; wr_idx = idx; wr_val = v; wr_data = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; wr_bit = 1'b0; wr_data = '0;
  endtask

  task automatic stop_all();
    @(negedge clk);
    stop_lo = 4'hF; stop_hi = 4'hF;
    @(negedge clk);
    stop_lo = '0; stop_hi = '0;
  endtask

  task automatic t_reset();
    chk("R4 en_lo", 8'(en_lo), 8'h0);
    chk("R4 en_hi", 8'(en_hi), 8'h0);
    chk("R4 start", 8'({start_lo, start_hi}), 8'h0);
    chk("R4 early", 8'(early), 8'h0);
    chk("R3 rd reset", rd_data, 8'h00);
  endtask

  task automatic t_lower_start();
    wr_byte(1'b0, 8'h05);
    chk("R1 start pulse", 8'(start_lo), 8'h05);
    chk("R3 rd after write", rd_data, 8'h00);
    @(negedge clk);
    chk("R2 pulse cleared", 8'(start_lo), 8'h00);
    chk("R1 enable set", 8'(en_lo), 8'h05);
    wr_byte(1'b0, 8'h00);
    chk("R1 zero write no start", 8'(start_lo), 8'h00);
    @(negedge clk);
    chk("R1 zero write keeps en", 8'(en_lo), 8'h05);
  endtask

  task automatic t_retrigger();
    wr_byte(1'b0, 8'h01);
    chk("R9 retrigger pulse", 8'(start_lo), 8'h01);
    @(negedge clk);
    chk("R9 en kept", 8'(en_lo), 8'h05);
  endtask

  task automatic t_reserved();
    stop_all();
    wr_byte(1'b0, 8'hF0);
    chk("R5 lo reserved start", 8'(start_lo), 8'h00);
    @(negedge clk);
    chk("R5 lo reserved en", 8'(en_lo), 8'h00);
    wr_byte(1'b1, 8'hF5);
    chk("R5 hi reserved start", 8'({start_lo, start_hi}), 8'h00);
    @(negedge clk);
    chk("R5 hi reserved en", 8'({en_lo, en_hi}), 8'h00);
  endtask

  task automatic t_upper();
    mode8 = 4'b1010;
    wr_byte(1'b1, 8'h0A);
    chk("R6 start_hi", 8'(start_hi), 8'h0A);
    chk("R6 start_lo quiet", 8'(start_lo), 8'h00);
    @(negedge clk);
    chk("R6 en_hi", 8'(en_hi), 8'h0A);
    chk("R6 en_lo quiet", 8'(en_lo), 8'h00);
  endtask

  task automatic t_mode();
    stop_all();
    mode8 = 4'b1010;
    wr_byte(1'b0, 8'h02);
    chk("R7 8-bit no hi start", 8'(start_hi), 8'h00);
    @(negedge clk);
    chk("R7 8-bit en_lo", 8'(en_lo), 8'h02);
    chk("R7 8-bit en_hi", 8'(en_hi), 8'h00);
    stop_all();
    mode8 = 4'b0000;
    wr_byte(1'b0, 8'h08);
    chk("R7 16-bit hi start", 8'(start_hi), 8'h08);
    @(negedge clk);
    chk("R7 16-bit en both", 8'({en_lo, en_hi}), 8'h88);
    stop_lo = 4'b1000;
    @(negedge clk);
    stop_lo = '0;
    chk("R10 16-bit stop both", 8'({en_lo, en_hi}), 8'h00);
  endtask

  task automatic t_stop();
    wr_byte(1'b0, 8'h0F);
    @(negedge clk);
    stop_lo = 4'b0100;
    @(negedge clk);
    stop_lo = '0;
    chk("R10 stop clears", 8'(en_lo), 8'h0B);
    // start pending in the same cycle as stop
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    stop_lo = 4'b0100;
    @(negedge clk);
    stop_lo = '0;
    chk("R10 start wins", 8'(en_lo), 8'h0F);
  endtask

  task automatic t_bitwrite();
    stop_all();
    wr_one(1'b0, 3'd2, 1'b1);
    chk("R11 single bit start", 8'(start_lo), 8'h04);
    @(negedge clk);
    chk("R11 single bit en", 8'(en_lo), 8'h04);
    wr_one(1'b0, 3'd1, 1'b0);
    chk("R11 bit zero no start", 8'(start_lo), 8'h00);
    mode8 = 4'b1010;
    wr_one(1'b1, 3'd3, 1'b1);
    chk("R11 hi single bit", 8'({start_lo, start_hi}), 8'h08);
  endtask

  task automatic settle_try(logic nf, int idle, logic exp, string req);
    @(negedge clk);
    nf_en = {3'b000, nf}; pin_chg = 4'b0001;
    @(negedge clk);
    pin_chg = '0;
    repeat (idle) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_bit = 1'b0; wr_data = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk(req, 8'(early), {7'b0, exp});
    repeat (6) @(negedge clk);
  endtask

  task automatic t_settle();
    settle_try(1'b0, 0, 1'b1, "R8 raw early");
    settle_try(1'b0, 1, 1'b0, "R8 raw on time");
    settle_try(1'b1, 2, 1'b1, "R8 filtered early");
    settle_try(1'b1, 3, 1'b0, "R8 filtered on time");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lower_start();
    t_retrigger();
    t_reserved();
    t_upper();
    t_mode();
    t_stop();
    t_bitwrite();
    t_settle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule